// File: doc/BRIEF.md
# Dual-Clock Flushable FIFO

This block carries 40-bit words from a fast producer clock to a much slower consumer clock, with no fixed relation between the two clocks. The words are held in a 64-entry ring. The producer side owns the write pointer and the consumer side owns the read pointer. Each pointer is turned into Gray code and passed through a flop chain into the other clock, where it drives the full test or the empty test. The flags it raises are pessimistic. A flag can stay set for a few cycles after the real state has moved on, but it never clears too early.

A flush request enters on the producer side. It discards all unread words. A four-phase request/acknowledge exchange between the two clocks resets both pointers. The exchange is ordered so that no pointer jump crosses a clock boundary while the other side can act on it. While the flush is under way, the producer sees the FIFO as not full but its writes are dropped. The consumer sees the FIFO as empty.

Each clock has its own active-low reset. The reset asserts asynchronously and is released through a two-flop synchroniser inside the block.

Top module: `xdom_fifo`

## Requirements
- R1: After reset, rd_empty is 1, wr_full is 0 and rd_data is all zeros.
- R2: Accepted words come out at rd_data in the order they were written, with no loss and no duplication.
- R3: Once 64 accepted words are unread, wr_full is 1 from the write-clock edge that accepted the 64th word.
- R4: A write with wr_en high while wr_full is 1 is dropped and does not change the stored contents.
- R5: A read with rd_en high while rd_empty is 1 is dropped, and rd_data keeps its value.
- R6: rd_empty never reads 0 while no unread word exists, and wr_full never reads 0 while 64 unread words exist.
- R7: rd_data is registered. It takes the next word on the read-clock edge that accepts a read and holds its value on all other edges.
- R8: A one-cycle flush pulse, sampled on wr_clk, leaves the FIFO empty: rd_empty is 1 and wr_full is 0. Words written before the flush are never delivered.
- R9: Writes issued while a flush handshake is in progress are dropped.
- R10: Both pointers wrap modulo 64, and a step of a pointer that crosses domains changes one bit of its Gray code.
- R11: After a write, rd_empty clears within three read-clock edges. After a read from a full FIFO, wr_full clears within three write-clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | 40 | Word to store |
| flush | input | 1 | Discard all unread words (sampled on wr_clk) |
| wr_full | output | 1 | No free entry for a write |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | 40 | Registered output word |
| rd_empty | output | 1 | No word available for a read |

## Verification
The ring is driven with four patterns. A short burst followed by a drain shows whether order is kept. A fill well past capacity, followed by a drain, checks both the full boundary and that overflow writes are dropped. Long concurrent traffic with irregular gaps crosses the wrap point many times. Flushes from a half-full FIFO and from a full FIFO check that stale words vanish and that writes during the flush are lost. A reference queue in the bench flags any clock on which a flag is clear while the model says it must be set. The flag latency probes show the difference between a slow synchroniser and a flag that never clears.

// File: rtl/xdf_pkg.sv
package xdf_pkg;

  // Producer-side flush sequencing.
  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,  // normal operation
    FL_REQ  = 2'd1,  // request raised, waiting for consumer acknowledge
    FL_CLR  = 2'd2,  // write pointer just cleared, request still high
    FL_WAIT = 2'd3   // request dropped, waiting for acknowledge to fall
  } flush_st_e;

endpackage

// File: rtl/xdf_sync.sv
// Multi-stage flop chain for signals entering a clock domain.
module xdf_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/xdf_gray_ptr.sv
// Binary ring pointer with a registered Gray copy for domain crossing.
module xdf_gray_ptr #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [PTR_W-2:0] addr,
  output logic [PTR_W-1:0] gray
);

  logic [PTR_W-1:0] bin_q, bin_d, gray_d;

  always_comb begin
    bin_d = bin_q;
    if (clr) begin
      bin_d = '0;
    end else if (adv) begin
      bin_d = bin_q + 1'b1;
    end
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
    end else begin
      bin_q <= bin_d;
      gray  <= gray_d;
    end
  end

  assign addr = bin_q[PTR_W-2:0];

endmodule

// File: rtl/xdf_ring_mem.sv
// Storage ring: written on the producer clock, read into a register on the consumer clock.
module xdf_ring_mem #(
  parameter int DATA_W = 40,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= cells[raddr];
    end
  end

endmodule

// File: rtl/xdf_flush_wr.sv
// Producer-side flush sequencer: four-phase request/acknowledge with the consumer.
module xdf_flush_wr
  import xdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic ack_s,
  output logic req,
  output logic ptr_clr,
  output logic busy
);

  flush_st_e st_q, st_d;
  logic      req_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FL_IDLE: if (flush) st_d = FL_REQ;
      FL_REQ:  if (ack_s) st_d = FL_CLR;
      FL_CLR:  st_d = FL_WAIT;
      FL_WAIT: if (!ack_s) st_d = FL_IDLE;
      default: st_d = FL_IDLE;
    endcase
    req_d = (st_d == FL_REQ) || (st_d == FL_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FL_IDLE;
      req  <= 1'b0;
    end else begin
      st_q <= st_d;
      req  <= req_d;
    end
  end

  // Pointer clears while the request is still high, one edge before it drops.
  assign ptr_clr = (st_q == FL_REQ) && ack_s;
  assign busy    = (st_q != FL_IDLE);

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
  parameter int DATA_W      = 40,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);

  localparam int PTR_W = ADDR_W + 1;

  logic              wr_rst_s_n, rd_rst_s_n;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_busy, wr_req, wr_ptr_clr, wr_ack_s;
  logic              rd_req_s, rd_ack_q, rd_ack_d, rd_hold;
  logic              wr_take, rd_take;

  // Reset release synchronisers
  xdf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(wr_rst_s_n));
  xdf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(rd_rst_s_n));

  // ---------------- producer domain ----------------
  xdf_flush_wr u_flush (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .flush(flush), .ack_s(wr_ack_s),
    .req(wr_req), .ptr_clr(wr_ptr_clr), .busy(wr_busy));

  xdf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rptr_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .d(rd_gray), .q(rd_gray_s));

  xdf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .d(rd_ack_q), .q(wr_ack_s));

  // Full: the Gray pointers differ only in their two top bits (wrapped once).
  assign wr_full = !wr_busy &&
                   (wr_gray == {~rd_gray_s[PTR_W-1:PTR_W-2], rd_gray_s[PTR_W-3:0]});
  assign wr_take = wr_en && !wr_full && !wr_busy;

  xdf_gray_ptr #(.PTR_W(PTR_W)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_s_n), .adv(wr_take), .clr(wr_ptr_clr),
    .addr(wr_addr), .gray(wr_gray));

  // ---------------- consumer domain ----------------
  xdf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wptr_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .d(wr_gray), .q(wr_gray_s));

  xdf_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .d(wr_req), .q(rd_req_s));

  assign rd_ack_d = rd_req_s;

  always_ff @(posedge rd_clk or negedge rd_rst_s_n) begin
    if (!rd_rst_s_n) begin
      rd_ack_q <= 1'b0;
    end else begin
      rd_ack_q <= rd_ack_d;
    end
  end

  // The acknowledge lags the request by one edge, so empty is held one extra
  // cycle after the request falls and the cleared write pointer has settled.
  assign rd_hold  = rd_req_s || rd_ack_q;
  assign rd_empty = rd_hold || (rd_gray == wr_gray_s);
  assign rd_take  = rd_en && !rd_empty;

  xdf_gray_ptr #(.PTR_W(PTR_W)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_s_n), .adv(rd_take), .clr(rd_req_s),
    .addr(rd_addr), .gray(rd_gray));

  // ---------------- storage ----------------
  xdf_ring_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(wr_take), .waddr(wr_addr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_s_n), .re(rd_take), .raddr(rd_addr),
    .rdata(rd_data));

endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter int DATA_W = 40,
  parameter int PTR_W  = 7
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_busy,
  input logic [PTR_W-1:0]  wr_gray,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic              rd_empty,
  input logic              rd_hold,
  input logic [PTR_W-1:0]  rd_gray,
  input logic [DATA_W-1:0] rd_data
);

  // R4: a write against a full ring leaves the write pointer where it was
  assert_full_blocks_write_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_full && wr_en) |=> $stable(wr_gray));

  // R5: a read against an empty ring moves neither the pointer nor the output
  assert_empty_blocks_read_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && rd_en && !rd_hold) |=> ($stable(rd_gray) && $stable(rd_data)));

  // R7: the output register only changes on an accepted read
  assert_rdata_hold_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_en && !rd_empty) |=> $stable(rd_data));

  // R8: when the producer leaves the flush sequence its pointer is at zero
  assert_flush_zeroes_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(wr_busy) |-> (wr_gray == '0));

  // R9: writes during a flush never advance the pointer
  assert_flush_drops_write_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_busy && wr_en) |=> (wr_gray == $past(wr_gray) || wr_gray == '0));

  // R10: outside a flush, each crossing pointer steps by a single Gray bit
  assert_wr_gray_step_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_busy |=> $onehot0(wr_gray ^ $past(wr_gray)));

  assert_rd_gray_step_R10: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_hold |=> $onehot0(rd_gray ^ $past(rd_gray)));

endmodule

bind xdom_fifo xdom_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_s_n), .wr_en(wr_en), .wr_full(wr_full),
  .wr_busy(wr_busy), .wr_gray(wr_gray),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_s_n), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_hold(rd_hold), .rd_gray(rd_gray), .rd_data(rd_data));

// File: tb/xdom_fifo_tb.sv
module xdom_fifo_tb;

  localparam int DW    = 40;
  localparam int DEPTH = 64;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, flush = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_empty;

  int            n_chk = 0, n_fail = 0;
  bit            mon_en = 1'b0, in_flush = 1'b0;
  logic [DW-1:0] model_q [$];
  logic [DW-1:0] last_rd = '0;

  always #10  wr_clk = ~wr_clk;   // 50 MHz producer clock
  always #161 rd_clk = ~rd_clk;   // roughly 16x slower, unrelated consumer clock

  xdom_fifo u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .flush(flush), .wr_full(wr_full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d, output bit took);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    took    = !wr_full && !in_flush;
    if (took) model_q.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(output bit took);
    logic [DW-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1'b1;
    took  = !rd_empty;
    exp   = took ? model_q.pop_front() : last_rd;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (took) chk(rd_data === exp, "R2/R7 word order", 64'(rd_data), 64'(exp));
    else      chk(rd_data === exp, "R5 output held on empty read", 64'(rd_data), 64'(exp));
    last_rd = rd_data;
  endtask

  task automatic do_flush(input bit poke_write);
    bit t;
    @(negedge wr_clk);
    in_flush = 1'b1;
    flush    = 1'b1;
    @(negedge wr_clk);
    flush = 1'b0;
    if (poke_write) do_write(40'hDEAD_BEEF_01, t);   // R9: must be dropped
    repeat (24) @(negedge rd_clk);
    model_q.delete();
    in_flush = 1'b0;
    chk(rd_empty === 1'b1, "R8 empty after flush", 64'(rd_empty), 64'd1);
    chk(wr_full === 1'b0, "R8 not full after flush", 64'(wr_full), 64'd0);
  endtask

  // R6: pessimistic flags compared with the reference queue on every clock
  always @(posedge rd_clk) begin
    #40;
    if (mon_en && !in_flush)
      chk(!(!rd_empty && model_q.size() == 0), "R6 empty cleared with nothing stored",
          64'(rd_empty), 64'd1);
  end

  always @(posedge wr_clk) begin
    #5;
    if (mon_en && !in_flush)
      chk(!(!wr_full && model_q.size() >= DEPTH), "R6 full cleared with ring full",
          64'(wr_full), 64'd1);
  end

  initial begin
    #4_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit t;
    int got;
    #1000;
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);

    // R1: reset state
    chk(rd_empty === 1'b1, "R1 empty at reset", 64'(rd_empty), 64'd1);
    chk(wr_full === 1'b0, "R1 full at reset", 64'(wr_full), 64'd0);
    chk(rd_data === '0, "R1 rd_data at reset", 64'(rd_data), 64'd0);
    mon_en = 1'b1;

    // R11: a single write shows up within three read edges
    do_write(40'h12_3456_789A, t);
    repeat (3) @(posedge rd_clk);
    #10;
    chk(rd_empty === 1'b0, "R11 empty clear latency", 64'(rd_empty), 64'd0);
    do_read(t);

    // R2: short burst then drain
    for (int i = 0; i < 10; i++) do_write(40'(i * 40'h11_0000_0101 + 7), t);
    repeat (4) @(negedge rd_clk);
    for (int i = 0; i < 10; i++) do_read(t);

    // R5: reads on an empty ring are dropped
    repeat (4) @(negedge rd_clk);
    for (int i = 0; i < 3; i++) do_read(t);
    chk(t == 1'b0, "R5 read taken while empty", 64'(t), 64'd0);

    // R3/R4: overfill then drain
    for (int i = 0; i < 70; i++) do_write(40'hA0_0000_0000 | 40'(i), t);
    chk(model_q.size() == DEPTH, "R4 accepted count", 64'(model_q.size()), 64'(DEPTH));
    chk(wr_full === 1'b1, "R3 full at 64 words", 64'(wr_full), 64'd1);
    do_read(t);
    repeat (3) @(posedge wr_clk);
    #5;
    chk(wr_full === 1'b0, "R11 full clear latency", 64'(wr_full), 64'd0);
    for (int i = 1; i < DEPTH; i++) do_read(t);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R4 no overflow word stored", 64'(rd_empty), 64'd1);
    do_write(40'h55_5555_5555, t);
    repeat (4) @(negedge rd_clk);
    do_read(t);

    // R10: concurrent traffic with irregular gaps, many wraps
    got = 0;
    fork
      begin
        for (int i = 0; i < 150; i++) begin
          bit ok;
          ok = 1'b0;
          while (!ok) do_write(40'(i * 7919 + 3) ^ 40'hC3_0000_0000, ok);
          repeat ($urandom_range(0, 30)) @(negedge wr_clk);
        end
      end
      begin
        while (got < 150) begin
          bit r;
          do_read(r);
          if (r) got++;
        end
      end
    join
    chk(got == 150 && model_q.size() == 0, "R10 wrap traffic count",
        64'(model_q.size()), 64'd0);

    // R8/R9: flush from half full, with a write issued mid-flush
    for (int i = 0; i < 30; i++) do_write(40'hF0_0000_0000 | 40'(i), t);
    do_flush(1'b1);
    for (int i = 0; i < 5; i++) do_write(40'h77_0000_0000 | 40'(i), t);
    repeat (4) @(negedge rd_clk);
    for (int i = 0; i < 5; i++) do_read(t);   // R9: poked word must not appear
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R9 write during flush dropped", 64'(rd_empty), 64'd1);

    // R8: flush from full
    for (int i = 0; i < DEPTH; i++) do_write(40'hBB_0000_0000 | 40'(i), t);
    chk(wr_full === 1'b1, "R3 full before flush", 64'(wr_full), 64'd1);
    do_flush(1'b0);
    do_write(40'h99_8877_6655, t);
    repeat (4) @(negedge rd_clk);
    do_read(t);
    chk(t == 1'b1, "R8 ring usable after flush", 64'(t), 64'd1);

    mon_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule